// File: doc/BRIEF.md
# Byte Mailbox Responder

This block is the controller-side end of a three-register byte mailbox used for request/response traffic between a host and a management controller. The host sees a data register, a control/status register and a flags register. To run one step, the host writes a byte into the data register and a control code into the control register, then sets the busy flag. After a programmable pause, the responder decodes the control code and carries out the step. It then publishes a status code and, where the step returns one, a data byte, and it clears busy.

A request is written as a sequence of steps: one write-start, any number of write-next steps and one write-end. The responder stores the request bytes in order. The response is the stored request, looped back. The host collects it with one read-start, then read-next steps, then a read-end. Error codes appear in the data register at the end of each phase. A control code that does not fit the current phase abandons the transaction. The pause before busy clears lets a host sequencer's polling loop be tested against a slow controller.

Top module: `bmb_responder`

## Requirements
- R1: After reset, the data register reads 0x00, the status register reads 0xC0 and the flags register reads 0x40.
- R2: Register addresses are 0 for data, 1 for control (write) and status (read), and 2 for flags. Address 3 reads 0x00. Flags bit 7 is receive-ready, bit 6 is transmit-ready and bit 0 is busy. Bits 5:1 always read 0, so the flags register never reads 0xFF.
- R3: Writing the flags register with bit 0 set sets busy. Busy then reads 1 for exactly BUSY_DELAY+1 clock cycles and clears when the step is complete.
- R4: While busy is set, host writes to the data, control and flags registers are ignored.
- R5: Control codes 0x40 to 0x46 have bit 7 clear, bits 6:5 equal to 10 and a phase in the low nibble: 0 get-status, 1 write-start, 2 write-next, 3 write-end, 4 read-start, 5 read-next, 6 read-end. The status of an accepted step is its code with bit 7 set (0xC0 to 0xC6). The status changes only when a step completes.
- R6: Write-start (0x41) is accepted only when idle and stores the data byte as request byte 0. Write-next (0x42) appends one byte. Write-end (0x43) appends the final byte, reports status 0xC3 and data 0x00, and sets flags to 0x80.
- R7: Once DEPTH (80) request bytes are stored, transmit-ready clears. Any further request byte is dropped. The write-end of such a request reports data 0x05 (buffer full) and status 0xC3, offers no response, and leaves flags at 0x40.
- R8: After a good write-end, read-start (0x44) presents request byte 0 and each read-next (0x45) presents the next byte in order. The status is 0xC4 for the first byte, 0xC5 for later bytes, and 0xC6 for the byte that is last. Receive-ready reads 1 while bytes remain and 0 once the last byte is presented. Requests are 2 to DEPTH bytes long.
- R9: Read-end (0x46) after the last byte reports status 0xC0 and data 0x00, and returns flags to 0x40.
- R10: A well-formed control code that does not fit the current phase reports data 0x02 (illegal control) and status 0xC0, and abandons the transaction. Examples are read-next when idle, write-next when idle, read-end before the last byte and read-start after an overflowed request.
- R11: A code with bit 7 set, bit 4 set, bits 6:5 other than 10, or a phase above 6 is handled as illegal control: data 0x02, status 0xC0. This includes the management-stream codes 0x60 to 0x66.
- R12: Get-status (0x40) reports status 0xC0. When idle, it reports data 0x00. When a transaction is in progress, it reports data 0x01 (aborted) and abandons the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select: 0 data, 1 control/status, 2 flags |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |

## Verification
The bench targets the storage limit. A request of DEPTH+1 bytes must drop its last byte, clear transmit-ready at exactly DEPTH bytes and report buffer-full. A wrong comparison would either write past the store or flag the error one byte early. The bench checks 2-byte and 80-byte responses, where a last-byte detection that is off by one gives 0xC5 instead of 0xC6 or the wrong receive-ready. It writes the control register while busy is set, so a latch that is not frozen during a step would turn a later get-status into an illegal-control error. It also sends codes from the other stream and aborts mid-write; a design that decodes only the low nibble, or never reports aborted, gives the wrong data byte.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

    // Host-visible register addresses (the host sequencer decodes these)
    localparam logic [1:0] A_DATA  = 2'd0;
    localparam logic [1:0] A_CS    = 2'd1;
    localparam logic [1:0] A_FLAGS = 2'd2;

    // Flag bit positions
    localparam int F_RX   = 7;
    localparam int F_TX   = 6;
    localparam int F_BUSY = 0;

    // Stream field (bits 6:5) of the host stream
    localparam logic [1:0] STREAM_HOST = 2'b10;

    typedef enum logic [3:0] {
        PH_READY    = 4'd0,
        PH_WR_FIRST = 4'd1,
        PH_WR_MORE  = 4'd2,
        PH_WR_LAST  = 4'd3,
        PH_RD_FIRST = 4'd4,
        PH_RD_MORE  = 4'd5,
        PH_RD_LAST  = 4'd6
    } phase_e;

    typedef enum logic [7:0] {
        ERR_OK       = 8'h00,
        ERR_ABORTED  = 8'h01,
        ERR_BAD_CTRL = 8'h02,
        ERR_NO_RESP  = 8'h03,
        ERR_BAD_CMD  = 8'h04,
        ERR_FULL     = 8'h05
    } err_e;

    // Transaction progress as seen by the responder
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WRITING,
        SQ_HOLD,
        SQ_READING,
        SQ_TAIL
    } seq_e;

    typedef struct packed {
        logic   ok;
        phase_e phase;
    } cmd_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic busy;
    } flags_t;

    function automatic cmd_t decode_ctrl(input logic [7:0] code);
        cmd_t c;
        c.ok    = (code[7] == 1'b0) && (code[6:5] == STREAM_HOST) &&
                  (code[4] == 1'b0) && (code[3:0] <= 4'd6);
        c.phase = phase_e'(code[3:0]);
        return c;
    endfunction

    function automatic logic [7:0] status_code(input phase_e ph);
        return {1'b1, STREAM_HOST, 1'b0, ph};
    endfunction

    function automatic logic [7:0] pack_flags(input flags_t f);
        return {f.rx, f.tx, 5'b00000, f.busy};
    endfunction

endpackage

// File: rtl/bmb_regs.sv
module bmb_regs
    import bmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       fire,
    input  logic [7:0] status_in,
    input  logic [7:0] data_in,
    input  logic       rx_rdy,
    input  logic       tx_rdy,
    output logic       busy,
    output logic [7:0] cmd_code,
    output logic [7:0] cmd_byte
);

    flags_t fl;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cmd_code <= 8'h40;
            cmd_byte <= 8'h00;
        end else if (fire) begin
            busy <= 1'b0;
        end else if (host_wr && !busy) begin
            case (host_addr)
                A_DATA:  cmd_byte <= host_wdata;
                A_CS:    cmd_code <= host_wdata;
                A_FLAGS: if (host_wdata[F_BUSY]) busy <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        fl.rx   = rx_rdy;
        fl.tx   = tx_rdy;
        fl.busy = busy;
        case (host_addr)
            A_DATA:  host_rdata = data_in;
            A_CS:    host_rdata = status_in;
            A_FLAGS: host_rdata = pack_flags(fl);
            default: host_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/bmb_pace.sv
module bmb_pace #(
    parameter int BUSY_DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic fire
);

    localparam int CW = $clog2(BUSY_DELAY + 2);

    logic [CW-1:0] cnt;

    assign fire = busy && (cnt == CW'(BUSY_DELAY));

    always_ff @(posedge clk) begin
        if (rst || !busy || fire) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/bmb_store.sv
module bmb_store #(
    parameter int DEPTH = 80,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < IW'(DEPTH))) cells[waddr] <= wdata;
    end

    assign rdata = (raddr < IW'(DEPTH)) ? cells[raddr] : 8'h00;

endmodule

// File: rtl/bmb_seq.sv
module bmb_seq
    import bmb_pkg::*;
#(
    parameter int DEPTH = 80,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [7:0]    cmd_code,
    input  logic [7:0]    cmd_byte,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    status,
    output logic [7:0]    data_out,
    output logic          rx_rdy,
    output logic          tx_rdy,
    output logic          mem_we,
    output logic [IW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [IW-1:0] mem_raddr
);

    seq_e          seq, seq_n;
    logic [IW-1:0] wr_cnt, wr_cnt_n;
    logic [IW-1:0] rd_idx, rd_idx_n;
    logic          ovf, ovf_n;
    logic [7:0]    status_n, data_n;
    logic          bad;
    logic          room;
    cmd_t          cmd;

    assign cmd       = decode_ctrl(cmd_code);
    assign room      = wr_cnt < IW'(DEPTH);
    assign mem_wdata = cmd_byte;
    assign mem_raddr = rd_idx;
    assign tx_rdy    = (seq == SQ_IDLE) || ((seq == SQ_WRITING) && room);
    assign rx_rdy    = (seq == SQ_HOLD) || (seq == SQ_READING);

    always_comb begin
        seq_n     = seq;
        wr_cnt_n  = wr_cnt;
        rd_idx_n  = rd_idx;
        ovf_n     = ovf;
        status_n  = status;
        data_n    = data_out;
        mem_we    = 1'b0;
        mem_waddr = wr_cnt;
        bad       = 1'b0;
        if (fire) begin
            if (!cmd.ok) begin
                bad = 1'b1;
            end else begin
                case (cmd.phase)
                    PH_READY: begin
                        status_n = status_code(PH_READY);
                        data_n   = (seq == SQ_IDLE) ? ERR_OK : ERR_ABORTED;
                        seq_n    = SQ_IDLE;
                    end
                    PH_WR_FIRST: begin
                        if (seq == SQ_IDLE) begin
                            mem_we    = 1'b1;
                            mem_waddr = '0;
                            wr_cnt_n  = IW'(1);
                            rd_idx_n  = '0;
                            ovf_n     = 1'b0;
                            status_n  = status_code(PH_WR_FIRST);
                            seq_n     = SQ_WRITING;
                        end else bad = 1'b1;
                    end
                    PH_WR_MORE, PH_WR_LAST: begin
                        if (seq == SQ_WRITING) begin
                            if (room) begin
                                mem_we   = 1'b1;
                                wr_cnt_n = wr_cnt + 1'b1;
                            end else begin
                                ovf_n = 1'b1;
                            end
                            status_n = status_code(cmd.phase);
                            if (cmd.phase == PH_WR_LAST) begin
                                if (ovf_n) begin
                                    data_n = ERR_FULL;
                                    seq_n  = SQ_IDLE;
                                end else begin
                                    data_n = ERR_OK;
                                    seq_n  = SQ_HOLD;
                                end
                            end
                        end else bad = 1'b1;
                    end
                    PH_RD_FIRST: begin
                        if (seq == SQ_HOLD) begin
                            data_n   = mem_rdata;
                            rd_idx_n = IW'(1);
                            if (wr_cnt == IW'(1)) begin
                                status_n = status_code(PH_RD_LAST);
                                seq_n    = SQ_TAIL;
                            end else begin
                                status_n = status_code(PH_RD_FIRST);
                                seq_n    = SQ_READING;
                            end
                        end else bad = 1'b1;
                    end
                    PH_RD_MORE: begin
                        if (seq == SQ_READING) begin
                            data_n   = mem_rdata;
                            rd_idx_n = rd_idx + 1'b1;
                            if (rd_idx_n == wr_cnt) begin
                                status_n = status_code(PH_RD_LAST);
                                seq_n    = SQ_TAIL;
                            end else begin
                                status_n = status_code(PH_RD_MORE);
                            end
                        end else bad = 1'b1;
                    end
                    PH_RD_LAST: begin
                        if (seq == SQ_TAIL) begin
                            status_n = status_code(PH_READY);
                            data_n   = ERR_OK;
                            seq_n    = SQ_IDLE;
                        end else bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
            end
            if (bad) begin
                mem_we   = 1'b0;
                status_n = status_code(PH_READY);
                data_n   = ERR_BAD_CTRL;
                seq_n    = SQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq      <= SQ_IDLE;
            wr_cnt   <= '0;
            rd_idx   <= '0;
            ovf      <= 1'b0;
            status   <= status_code(PH_READY);
            data_out <= ERR_OK;
        end else begin
            seq      <= seq_n;
            wr_cnt   <= wr_cnt_n;
            rd_idx   <= rd_idx_n;
            ovf      <= ovf_n;
            status   <= status_n;
            data_out <= data_n;
        end
    end

endmodule

// File: rtl/bmb_responder.sv
module bmb_responder #(
    parameter int DEPTH      = 80,
    parameter int BUSY_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);

    localparam int IW = $clog2(DEPTH + 1);

    logic          busy;
    logic          fire;
    logic [7:0]    cmd_code;
    logic [7:0]    cmd_byte;
    logic [7:0]    status;
    logic [7:0]    data_out;
    logic          rx_rdy;
    logic          tx_rdy;
    logic          mem_we;
    logic [IW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic [IW-1:0] mem_raddr;
    logic [7:0]    mem_rdata;

    bmb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .fire       (fire),
        .status_in  (status),
        .data_in    (data_out),
        .rx_rdy     (rx_rdy),
        .tx_rdy     (tx_rdy),
        .busy       (busy),
        .cmd_code   (cmd_code),
        .cmd_byte   (cmd_byte)
    );

    bmb_pace #(.BUSY_DELAY(BUSY_DELAY)) u_pace (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .fire (fire)
    );

    bmb_seq #(.DEPTH(DEPTH), .IW(IW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .cmd_code  (cmd_code),
        .cmd_byte  (cmd_byte),
        .mem_rdata (mem_rdata),
        .status    (status),
        .data_out  (data_out),
        .rx_rdy    (rx_rdy),
        .tx_rdy    (tx_rdy),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr)
    );

    bmb_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/bmb_chk.sv
module bmb_chk #(
    parameter int BUSY_DELAY = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic [7:0] host_rdata,
    input logic       busy,
    input logic       fire,
    input logic [7:0] status,
    input logic       rx_rdy,
    input logic       tx_rdy,
    input logic [7:0] cmd_code,
    input logic [7:0] cmd_byte
);

    localparam int HW = $clog2(BUSY_DELAY + 3);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)       hi_cnt <= '0;
        else if (busy) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    assert_flags_not_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd2) |-> (host_rdata != 8'hFF));

    assert_ready_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(rx_rdy && tx_rdy));

    assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (hi_cnt == HW'(BUSY_DELAY + 1)));

    assert_frozen_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr) |=> ($stable(cmd_code) && $stable(cmd_byte)));

    assert_status_form_R5: assert property (@(posedge clk) disable iff (rst)
        (status[7:4] == 4'hC) && (status[3:0] <= 4'd6));

    assert_status_steady_R5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(status));

endmodule

bind bmb_responder bmb_chk #(.BUSY_DELAY(BUSY_DELAY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .busy       (busy),
    .fire       (fire),
    .status     (status),
    .rx_rdy     (rx_rdy),
    .tx_rdy     (tx_rdy),
    .cmd_code   (cmd_code),
    .cmd_byte   (cmd_byte)
);

// File: tb/sim_bmb_responder.sv
`timescale 1ns/1ps
module sim_bmb_responder;

    localparam int DEPTH = 80;
    localparam int DLY   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int total = 0;
    int bad   = 0;
    int last_hi = 0;
    logic [7:0] msg [0:127];

    always #2.5 clk = ~clk;

    bmb_responder #(.DEPTH(DEPTH), .BUSY_DELAY(DLY)) u0 (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [7:0] exp_rd_status(input int i, input int n);
        if (i == n - 1) return 8'hC6;
        if (i == 0)     return 8'hC4;
        return 8'hC5;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #0.2;
        v = host_rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        host_addr  = a;
        host_wdata = v;
        host_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic chk3(input string req, input logic [7:0] d, input logic [7:0] s, input logic [7:0] f);
        logic [7:0] v;
        reg_rd(2'd0, v); chk({req, " data"}, v, d);
        reg_rd(2'd1, v); chk({req, " status"}, v, s);
        reg_rd(2'd2, v); chk({req, " flags"}, v, f);
    endtask

    task automatic wait_idle();
        logic [7:0] f;
        last_hi = 0;
        reg_rd(2'd2, f);
        while (f[0] && last_hi < 1000) begin
            last_hi++;
            @(negedge clk);
            reg_rd(2'd2, f);
        end
    endtask

    task automatic step(input logic [7:0] code, input logic [7:0] b);
        reg_wr(2'd0, b);
        reg_wr(2'd1, code);
        reg_wr(2'd2, 8'h01);
        wait_idle();
    endtask

    task automatic run_msg(input int n, input string tag);
        logic [7:0] v;
        step(8'h41, msg[0]);
        reg_rd(2'd1, v); chk({tag, " R6 write-start status"}, v, 8'hC1);
        for (int i = 1; i < n - 1; i++) begin
            step(8'h42, msg[i]);
            reg_rd(2'd1, v); chk({tag, " R6 write-next status"}, v, 8'hC2);
        end
        step(8'h43, msg[n-1]);
        chk3({tag, " R6 write-end"}, 8'h00, 8'hC3, 8'h80);
        step(8'h44, 8'h00);
        chk3({tag, " R8 read-start"}, msg[0], exp_rd_status(0, n), (n == 1) ? 8'h00 : 8'h80);
        for (int i = 1; i < n; i++) begin
            step(8'h45, 8'h00);
            chk3({tag, " R8 read-next"}, msg[i], exp_rd_status(i, n), (i == n - 1) ? 8'h00 : 8'h80);
        end
        step(8'h46, 8'h00);
        chk3({tag, " R9 read-end"}, 8'h00, 8'hC0, 8'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd71531));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R2 unused address
        chk3("R1 reset", 8'h00, 8'hC0, 8'h40);
        reg_rd(2'd3, v); chk("R2 address 3", v, 8'h00);

        // R3 busy window length, R12 get-status from idle
        step(8'h40, 8'h00);
        chk("R3 busy cycles", 8'(last_hi), 8'(DLY + 1));
        chk3("R12 get-status idle", 8'h00, 8'hC0, 8'h40);

        // R4 writes during busy are ignored
        reg_wr(2'd0, 8'h5A);
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd1, 8'h44);
        reg_wr(2'd0, 8'hEE);
        wait_idle();
        chk3("R4 step with writes during busy", 8'h00, 8'hC0, 8'h40);
        reg_wr(2'd2, 8'h01);
        wait_idle();
        chk3("R4 control latch kept", 8'h00, 8'hC0, 8'h40);

        // R6 R8 R9 shortest and longest requests
        msg[0] = 8'hA5; msg[1] = 8'h3C;
        run_msg(2, "len2");
        for (int i = 0; i < DEPTH; i++) msg[i] = 8'(i * 7 + 3);
        run_msg(DEPTH, "len80");

        // R6 R8 R9 random requests
        for (int k = 0; k < 6; k++) begin
            int n;
            n = 2 + int'($urandom % (DEPTH - 1));
            for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
            run_msg(n, "rand");
        end

        // R7 overflow by one byte
        step(8'h41, 8'h11);
        for (int i = 1; i < DEPTH; i++) step(8'h42, 8'(i));
        chk3("R7 store full", 8'h00, 8'hC2, 8'h00);
        step(8'h43, 8'hFE);
        chk3("R7 buffer full", 8'h05, 8'hC3, 8'h40);
        step(8'h44, 8'h00);
        chk3("R10 read after overflow", 8'h02, 8'hC0, 8'h40);

        // R10 out-of-sequence codes
        step(8'h45, 8'h00);
        chk3("R10 read-next idle", 8'h02, 8'hC0, 8'h40);
        step(8'h42, 8'h00);
        chk3("R10 write-next idle", 8'h02, 8'hC0, 8'h40);
        step(8'h41, 8'h01); step(8'h42, 8'h02); step(8'h43, 8'h03);
        step(8'h44, 8'h00);
        chk3("R10 early read-start", 8'h01, 8'hC4, 8'h80);
        step(8'h46, 8'h00);
        chk3("R10 early read-end", 8'h02, 8'hC0, 8'h40);

        // R11 codes outside the host stream
        step(8'h61, 8'h00);
        chk3("R11 mgmt stream", 8'h02, 8'hC0, 8'h40);
        step(8'hC1, 8'h00);
        chk3("R11 bit7 set", 8'h02, 8'hC0, 8'h40);
        step(8'h47, 8'h00);
        chk3("R11 phase 7", 8'h02, 8'hC0, 8'h40);
        step(8'h51, 8'h00);
        chk3("R11 bit4 set", 8'h02, 8'hC0, 8'h40);

        // R12 abort in mid-write, then idle get-status
        step(8'h41, 8'h77);
        step(8'h40, 8'h00);
        chk3("R12 abort", 8'h01, 8'hC0, 8'h40);
        step(8'h40, 8'h00);
        chk3("R12 after abort", 8'h00, 8'hC0, 8'h40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule